// File: doc/BRIEF.md
# Phased Fidelity Mantissa Multiplier

This block multiplies two 8-bit floating-point mantissas, hidden bit included, on one small 5-by-7 multiplier array. Each operand is cut into a high and a low part. The four cross products of these parts are computed one per cycle and added into an accumulator, with each product shifted to its binary weight. A two-bit fidelity code chosen per operation sets how many of these phases run. A caller can therefore take a rough product in one cycle or the exact product in four. Exponent handling, normalization and accumulation across tiles belong to the caller.

A caller drives the operands and the fidelity code and pulses `start`. The block captures them and runs the selected phases in order of significance. When the last phase is done it presents the product on `prod` together with a one-cycle `done` pulse. The product then stays on `prod` until the next operation completes. When both low parts are zero, the operands fit the array directly and the block finishes after one phase.

Top module: `mpm_fid_mul`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done` and `prod` are 0 after that edge.
- R2: The number of phases is `fid`+1, except in the case of R6. `done` goes high after the clock edge that is that many edges after the edge that accepted `start`.
- R3: A mantissa `a` is split into `ah`=a[7:3] and `al`=a[2:0]. A mantissa `b` is split into `bh`=b[7:1] and `bl`=b[0]. The phases run in a fixed order: `ah*bh<<4`, then `al*bh<<1`, then `ah*bl<<3`, then `al*bl`. `prod` is the sum of the first fid+1 terms of this order.
- R4: With `fid`=0, `prod` equals `ah*bh<<4`. This is the result of a single phase.
- R5: With `fid`=3, `prod` equals the exact 16-bit product `a*b`.
- R6: When `al`=0 and `bl`=0, the operation runs one phase whatever `fid` is. `prod` is then the exact `a*b`.
- R7: A `start` that arrives while an operation is in progress is ignored. The running operation finishes with its own operands, fidelity and timing.
- R8: `done` is high for exactly one cycle per operation. `prod` does not change in any cycle in which `done` is not being raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only when idle |
| op_a | input | 8 | Mantissa A, hidden bit in bit 7 |
| op_b | input | 8 | Mantissa B, hidden bit in bit 7 |
| fid | input | 2 | Fidelity code: phase count minus one |
| prod | output | 16 | Accumulated product, held until the next completion |
| done | output | 1 | One-cycle pulse when `prod` is updated |

## Verification
Two events can fall in the same cycle: accepting a new `start` and finishing the current operation. The bench provokes this by raising `start` with different operands and fidelity in every cycle of a running operation, including the cycle in which its last phase runs. It then judges that the `done` timing and `prod` match the first operation alone. In a second check it starts a new operation in the cycle right after `done`. That operation must be accepted, and its result and latency must follow its own operands and fidelity.

// File: rtl/mpm_pkg.sv
// Package mpm_pkg
// Purpose : shared widths, phase encoding and weight shifts for the phased
//           mantissa multiplier.
// Assumes : operand widths are no narrower than the array dimensions.
package mpm_pkg;
    localparam int A_W    = 8;             // operand A mantissa width
    localparam int B_W    = 8;             // operand B mantissa width
    localparam int ARR_A  = 5;             // array input width on the A side
    localparam int ARR_B  = 7;             // array input width on the B side
    localparam int FID_W  = 2;             // fidelity code width
    localparam int A_LO_W = A_W - ARR_A;   // width of A low part
    localparam int B_LO_W = B_W - ARR_B;   // width of B low part
    localparam int PP_W   = ARR_A + ARR_B; // raw array product width
    localparam int P_W    = A_W + B_W;     // full product width
    localparam int SH_W   = 4;             // width of a shift amount

    typedef enum logic [1:0] {
        PH_HH = 2'd0,   // A high x B high
        PH_LH = 2'd1,   // A low  x B high
        PH_HL = 2'd2,   // A high x B low
        PH_LL = 2'd3    // A low  x B low
    } phase_t;

    localparam logic [SH_W-1:0] SH_HH = SH_W'(A_LO_W + B_LO_W);
    localparam logic [SH_W-1:0] SH_LH = SH_W'(B_LO_W);
    localparam logic [SH_W-1:0] SH_HL = SH_W'(A_LO_W);
    localparam logic [SH_W-1:0] SH_LL = '0;
endpackage

// File: rtl/mpm_split.sv
// Module mpm_split
// Purpose : cut both mantissas into high and low parts that fit the array,
//           and flag operands whose low parts are both zero.
// Assumes : purely combinational; the caller registers the operands.
module mpm_split
    import mpm_pkg::*;
(
    input  logic [A_W-1:0]    a_in,
    input  logic [B_W-1:0]    b_in,
    output logic [ARR_A-1:0]  a_hi,
    output logic [A_LO_W-1:0] a_lo,
    output logic [ARR_B-1:0]  b_hi,
    output logic [B_LO_W-1:0] b_lo,
    output logic              narrow
);
    // Slice fields and detect operands that fit the array in one phase.
    always_comb begin
        a_hi   = a_in[A_W-1 -: ARR_A];
        a_lo   = a_in[A_LO_W-1:0];
        b_hi   = b_in[B_W-1 -: ARR_B];
        b_lo   = b_in[B_LO_W-1:0];
        narrow = (a_lo == '0) && (b_lo == '0);
    end
endmodule

// File: rtl/mpm_array.sv
// Module mpm_array
// Purpose : the 5x7 multiplier array with its input selection and weight
//           shift. One phase yields one aligned partial product.
// Assumes : combinational; the phase comes from the sequencer.
module mpm_array
    import mpm_pkg::*;
(
    input  phase_t            phase,
    input  logic [ARR_A-1:0]  a_hi,
    input  logic [A_LO_W-1:0] a_lo,
    input  logic [ARR_B-1:0]  b_hi,
    input  logic [B_LO_W-1:0] b_lo,
    output logic [P_W-1:0]    pp_aligned
);
    logic [ARR_A-1:0] a_lo_x;
    logic [ARR_B-1:0] b_lo_x;
    logic [ARR_A-1:0] mul_x;
    logic [ARR_B-1:0] mul_y;
    logic [SH_W-1:0]  shamt;
    logic [PP_W-1:0]  pp_raw;

    // Zero-extend the low parts to the array input widths.
    always_comb begin
        a_lo_x = {{(ARR_A-A_LO_W){1'b0}}, a_lo};
        b_lo_x = {{(ARR_B-B_LO_W){1'b0}}, b_lo};
    end

    // Pick the array inputs and the weight shift for the current phase.
    always_comb begin
        case (phase)
            PH_HH:   begin mul_x = a_hi;   mul_y = b_hi;   shamt = SH_HH; end
            PH_LH:   begin mul_x = a_lo_x; mul_y = b_hi;   shamt = SH_LH; end
            PH_HL:   begin mul_x = a_hi;   mul_y = b_lo_x; shamt = SH_HL; end
            default: begin mul_x = a_lo_x; mul_y = b_lo_x; shamt = SH_LL; end
        endcase
    end

    // Multiply on the narrow array and move the result to its weight.
    always_comb begin
        pp_raw     = PP_W'(mul_x) * PP_W'(mul_y);
        pp_aligned = {{(P_W-PP_W){1'b0}}, pp_raw} << shamt;
    end
endmodule

// File: rtl/mpm_ctrl.sv
// Module mpm_ctrl
// Purpose : phase sequencer. It accepts a start when idle, steps through
//           phases 0..last and raises a one-cycle done after the last one.
// Assumes : synchronous active-low reset; start is ignored while busy.
module mpm_ctrl
    import mpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [FID_W-1:0] fid,
    input  logic             narrow,
    output logic             accept,
    output logic             step,
    output logic             last_step,
    output phase_t           phase,
    output logic             done
);
    logic             busy_q;
    logic [FID_W-1:0] phase_q;
    logic [FID_W-1:0] last_q;
    logic             done_q;

    // Decode the handshake from the current state.
    always_comb begin
        accept    = start && !busy_q;
        step      = busy_q;
        last_step = busy_q && (phase_q == last_q);
        phase     = phase_t'(phase_q);
        done      = done_q;
    end

    // Advance the phase counter and track the busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= '0;
            last_q  <= '0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            phase_q <= '0;
            last_q  <= narrow ? '0 : fid;
        end else if (busy_q) begin
            if (phase_q == last_q) begin
                busy_q <= 1'b0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // Register the completion pulse one cycle after the final phase.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last_step;
    end

    AST_PHASE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (phase_q <= last_q)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (phase_q != last_q)) |=> (busy_q && phase_q == $past(phase_q) + 1'b1)); // R7
endmodule

// File: rtl/mpm_fid_mul.sv
// Module mpm_fid_mul
// Purpose : top level. It captures the operands on an accepted start,
//           accumulates the aligned partial product of each phase and
//           presents the product with a done pulse.
// Assumes : synchronous active-low reset; operands are mantissas with the
//           hidden bit in the MSB.
module mpm_fid_mul
    import mpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [A_W-1:0]   op_a,
    input  logic [B_W-1:0]   op_b,
    input  logic [FID_W-1:0] fid,
    output logic [P_W-1:0]   prod,
    output logic             done
);
    logic [A_W-1:0]    a_q;
    logic [B_W-1:0]    b_q;
    logic [FID_W-1:0]  fid_q;
    logic [P_W-1:0]    acc_q;
    logic [P_W-1:0]    prod_q;

    logic [ARR_A-1:0]  in_a_hi, q_a_hi;
    logic [A_LO_W-1:0] in_a_lo, q_a_lo;
    logic [ARR_B-1:0]  in_b_hi, q_b_hi;
    logic [B_LO_W-1:0] in_b_lo, q_b_lo;
    logic              in_narrow, q_narrow;
    logic              accept, step, last_step;
    phase_t            phase;
    logic [P_W-1:0]    pp_aligned;
    logic [P_W-1:0]    acc_next;

    // The input-side split only feeds the narrow-operand check.
    mpm_split i_split_in (
        .a_in(op_a), .b_in(op_b),
        .a_hi(in_a_hi), .a_lo(in_a_lo), .b_hi(in_b_hi), .b_lo(in_b_lo),
        .narrow(in_narrow)
    );

    // The captured-side split feeds the array.
    mpm_split i_split_q (
        .a_in(a_q), .b_in(b_q),
        .a_hi(q_a_hi), .a_lo(q_a_lo), .b_hi(q_b_hi), .b_lo(q_b_lo),
        .narrow(q_narrow)
    );

    mpm_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .fid(fid),
        .narrow(in_narrow), .accept(accept), .step(step),
        .last_step(last_step), .phase(phase), .done(done)
    );

    mpm_array i_array (
        .phase(phase), .a_hi(q_a_hi), .a_lo(q_a_lo),
        .b_hi(q_b_hi), .b_lo(q_b_lo), .pp_aligned(pp_aligned)
    );

    // Add the current aligned partial product to the running sum.
    always_comb acc_next = acc_q + pp_aligned;

    // Capture the operands and fidelity when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            fid_q <= '0;
        end else if (accept) begin
            a_q   <= op_a;
            b_q   <= op_b;
            fid_q <= fid;
        end
    end

    // Clear the accumulator on accept and sum the partial products per phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (accept)  acc_q <= '0;
        else if (step)    acc_q <= acc_next;
    end

    // Latch the finished product for the caller.
    always_ff @(posedge clk) begin
        if (!rst_n)          prod_q <= '0;
        else if (last_step)  prod_q <= acc_next;
    end

    assign prod = prod_q;

    AST_FULL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fid_q == 2'd3) |-> (prod == P_W'(a_q) * P_W'(b_q))); // R5
    AST_NARROW_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q_narrow) |-> (prod == P_W'(a_q) * P_W'(b_q))); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (step && start) |=> ($stable(a_q) && $stable(b_q) && $stable(fid_q))); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(prod)); // R8
endmodule

// File: tb/test_mpm_fid_mul.sv
module test_mpm_fid_mul;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic [1:0]  fid = '0;
    logic [15:0] prod;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    mpm_fid_mul i_mpm_fid_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .fid(fid), .prod(prod), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected product from the phase order in R3.
    function automatic logic [15:0] exp_prod(input logic [7:0] a, input logic [7:0] b,
                                             input logic [1:0] f);
        logic [15:0] t [4];
        logic [15:0] s;
        int n;
        t[0] = 16'(a[7:3]) * 16'(b[7:1]) << 4;
        t[1] = 16'(a[2:0]) * 16'(b[7:1]) << 1;
        t[2] = 16'(a[7:3]) * 16'(b[0])   << 3;
        t[3] = 16'(a[2:0]) * 16'(b[0]);
        n = exp_phases(a, b, f);
        s = '0;
        for (int i = 0; i < n; i++) s = s + t[i];
        return s;
    endfunction

    function automatic int exp_phases(input logic [7:0] a, input logic [7:0] b,
                                      input logic [1:0] f);
        if (a[2:0] == 3'd0 && b[0] == 1'b0) return 1;
        return int'(f) + 1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one operation. When spam is set, a conflicting start is driven in
    // every busy cycle (R7).
    task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [1:0] f,
                          input bit spam, input string req);
        int n;
        n = exp_phases(a, b, f);
        @(negedge clk);
        op_a = a; op_b = b; fid = f; start = 1'b1;
        @(posedge clk); #1;
        start = spam;
        op_a = ~a; op_b = ~b; fid = ~f;
        for (int k = 1; k <= n; k++) begin
            @(posedge clk); #1;
            if (k < n) check(done == 1'b0, "R2", 32'(done), 32'd0);
        end
        start = 1'b0;
        check(done == 1'b1, "R2", 32'(done), 32'd1);
        check(prod == exp_prod(a, b, f), req, 32'(prod), 32'(exp_prod(a, b, f)));
        @(posedge clk); #1;
        check(done == 1'b0, "R8", 32'(done), 32'd0);
        check(prod == exp_prod(a, b, f), "R8", 32'(prod), 32'(exp_prod(a, b, f)));
    endtask

    initial begin
        int seed;
        logic [7:0] ra, rb;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1;
        check(done == 1'b0, "R1", 32'(done), 32'd0);
        check(prod == 16'd0, "R1", 32'(prod), 32'd0);
        rst_n = 1'b1;

        // Directed corner cases.
        run_op(8'hFF, 8'hFF, 2'd0, 1'b0, "R4");
        run_op(8'hFF, 8'hFF, 2'd1, 1'b0, "R3");
        run_op(8'hFF, 8'hFF, 2'd2, 1'b0, "R3");
        run_op(8'hFF, 8'hFF, 2'd3, 1'b0, "R5");
        check(prod == 16'hFE01, "R5", 32'(prod), 32'hFE01);
        run_op(8'h87, 8'hC1, 2'd3, 1'b0, "R5");
        run_op(8'hA8, 8'hB6, 2'd3, 1'b0, "R6");
        run_op(8'h80, 8'h80, 2'd2, 1'b0, "R6");
        run_op(8'h9B, 8'hE5, 2'd3, 1'b1, "R7");
        run_op(8'hC3, 8'h81, 2'd1, 1'b1, "R7");

        // Back-to-back: a start in the cycle right after done is accepted.
        run_op(8'hD7, 8'h93, 2'd2, 1'b0, "R3");
        run_op(8'h85, 8'hFF, 2'd3, 1'b0, "R5");

        // Random stimulus with the hidden bit set.
        for (int i = 0; i < 300; i++) begin
            ra = 8'($urandom) | 8'h80;
            rb = 8'($urandom) | 8'h80;
            run_op(ra, rb, 2'($urandom), 1'($urandom), "R3");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule